// File: doc/BRIEF.md
# Sequential Integer Square Root Unit

This unit computes the floor of the square root of an unsigned radicand that is 2N bits wide and produces an N-bit root. The arithmetic never multiplies. The unit keeps the running value x minus y squared in a signed difference register and updates it each cycle with one add or subtract. A partial-root register grows one root bit per cycle. A weight register holds a single set bit that moves right by two places per pass and sets the pace. After N passes the partial root holds a raw result. That raw result equals the true root for perfect squares. Otherwise it is odd and may be one too large.

A registered correction stage then reads the sign of the final difference. It lowers the raw result by one when the difference is negative and raises a result-valid flag. A caller pulses `init` with the radicand applied, waits for `raw_done` after N cycles, and reads the corrected `root` one cycle later. If the running difference becomes zero, the exact root has been found. A sticky flag then freezes the difference, and the partial root only shifts down into place.

Top module: `nr_isqrt`

## Requirements
- R1: With `rst` high at a clock edge (synchronous, active high), `raw_done`, `root_valid`, `root` and `raw_root` are all 0 after that edge.
- R2: An edge at which `init` is high captures `radicand`. After that edge, `raw_root` reads 0 and both `raw_done` and `root_valid` read 0.
- R3: `raw_done` rises exactly N clock edges after the last edge at which `init` was high. Between those points exactly one iteration runs per edge.
- R4: For a radicand that is not a perfect square, `raw_root` at the rise of `raw_done` is odd and equals either floor(sqrt(x)) or floor(sqrt(x))+1.
- R5: For a perfect-square radicand, `raw_root` at the rise of `raw_done` equals the exact root. Once the difference reaches zero, the difference is held and the partial root only shifts right by one place per pass.
- R6: `root_valid` rises one edge after `raw_done`. `root` then equals floor(sqrt(x)): the raw root minus one when the final difference is negative, and the raw root otherwise.
- R7: After completion, `root`, `root_valid`, `raw_root` and `raw_done` keep their values until the next `init` or reset.
- R8: An `init` pulse during an operation abandons that operation. The new radicand completes with the latency of R3 and with correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Start strobe; captures the radicand |
| radicand | input | 2N | Unsigned value whose root is taken |
| raw_root | output | N | Low N bits of the partial-root register (uncorrected result) |
| raw_done | output | 1 | High from the cycle after the last iteration until the next init |
| root | output | N | Corrected floor square root |
| root_valid | output | 1 | High while `root` holds a finished result |

## Verification
The bench builds the unit with N = 6, so the radicand is 12 bits wide. At that size every one of the 4096 radicands can be run in turn. The sweep covers every perfect square, including 0 and the largest square. It covers every value just below and just above a square, where the raw root lands on either side of the floor. It also covers the all-ones radicand and early exact detection, where the difference reaches zero in the first pass. Restarts in mid-operation are added with radicands that take different paths, and the hold behaviour is sampled on a stride through the sweep.

// File: rtl/nr_isqrt_pkg.sv
package nr_isqrt_pkg;

  // Action taken by one pass of the datapath
  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,  // exact root found: difference frozen, root shifts
    STEP_GROW   = 2'd1,  // difference non-negative: raise the current root bit
    STEP_SHRINK = 2'd2   // difference negative: lower the current root bit
  } step_e;

endpackage

// File: rtl/nr_isqrt_weight.sv
module nr_isqrt_weight #(
  parameter int N = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  output logic [2*N-1:0]  weight,
  output logic            active,
  output logic            raw_done
);

  localparam int RW = 2 * N;
  localparam logic [RW-1:0] W_INIT = RW'(1) << (RW - 2);

  // One pass per edge while the single weight bit is still in range
  assign active = |weight;

  always_ff @(posedge clk) begin
    if (rst) begin
      weight   <= '0;
      raw_done <= 1'b0;
    end else if (init) begin
      weight   <= W_INIT;
      raw_done <= 1'b0;
    end else if (active) begin
      weight   <= weight >> 2;
      raw_done <= weight[0];
    end
  end

  // R3: the weight register never carries more than one set bit
  a_r3_weight_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(weight));

  // R3: completion follows the pass in which the weight reached bit 0
  a_r3_done_after_lsb: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_done) |-> $past(weight[0]));

  // R2: init loads the start weight and clears completion
  a_r2_init_load: assert property (@(posedge clk) disable iff (rst)
    init |=> (weight == W_INIT) && !raw_done);

endmodule

// File: rtl/nr_isqrt_step.sv
module nr_isqrt_step
  import nr_isqrt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [2*N:0]    diff,
  input  logic [2*N-1:0]  part,
  input  logic [2*N-1:0]  weight,
  input  logic            exact_q,
  output logic [2*N:0]    diff_nxt,
  output logic [2*N-1:0]  part_nxt,
  output logic            exact_now
);

  localparam int RW = 2 * N;
  localparam int DW = 2 * N + 1;

  step_e           kind;
  logic [DW-1:0]   addend;
  logic [DW-1:0]   carry;
  logic [DW-1:0]   sum;
  logic [RW-1:0]   half;

  always_comb begin
    exact_now = (diff == '0) || exact_q;
    if (exact_now)          kind = STEP_HOLD;
    else if (!diff[DW-1])   kind = STEP_GROW;
    else                    kind = STEP_SHRINK;
  end

  // Single shared adder: diff -/+ part - weight
  always_comb begin
    if (kind == STEP_GROW) begin
      addend = ~{1'b0, part};
      carry  = {{(DW-1){1'b0}}, 1'b1};
    end else begin
      addend = {1'b0, part};
      carry  = '0;
    end
    sum  = diff + addend + carry - {1'b0, weight};
    half = part >> 1;
  end

  always_comb begin
    unique case (kind)
      STEP_GROW: begin
        diff_nxt = sum;
        part_nxt = half + weight;
      end
      STEP_SHRINK: begin
        diff_nxt = sum;
        part_nxt = half - weight;
      end
      default: begin
        diff_nxt = diff;
        part_nxt = half;
      end
    endcase
  end

endmodule

// File: rtl/nr_isqrt_fix.sv
module nr_isqrt_fix #(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          raw_done,
  input  logic [N-1:0]  raw_root,
  input  logic          diff_neg,
  output logic [N-1:0]  root,
  output logic          root_valid
);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      root       <= '0;
      root_valid <= 1'b0;
    end else if (raw_done && !root_valid) begin
      root       <= raw_root - {{(N-1){1'b0}}, diff_neg};
      root_valid <= 1'b1;
    end
  end

  // R7: a finished result holds until init or reset
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    (root_valid && !init) |=> root_valid && $stable(root));

  // R6: the corrected result comes one edge after raw completion
  a_r6_valid_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(root_valid) |-> raw_done && $past(raw_done));

endmodule

// File: rtl/nr_isqrt.sv
module nr_isqrt #(
  parameter int N = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            init,
  input  logic [2*N-1:0]  radicand,
  output logic [N-1:0]    raw_root,
  output logic            raw_done,
  output logic [N-1:0]    root,
  output logic            root_valid
);

  localparam int RW = 2 * N;
  localparam int DW = 2 * N + 1;

  if (N < 2) begin : g_bad_width
    $error("nr_isqrt: N must be at least 2");
  end

  logic [DW-1:0] diff;
  logic [DW-1:0] diff_nxt;
  logic [RW-1:0] part;
  logic [RW-1:0] part_nxt;
  logic [RW-1:0] weight;
  logic          active;
  logic          exact_q;
  logic          exact_now;

  nr_isqrt_weight #(.N(N)) u_weight (
    .clk      (clk),
    .rst      (rst),
    .init     (init),
    .weight   (weight),
    .active   (active),
    .raw_done (raw_done)
  );

  nr_isqrt_step #(.N(N)) u_step (
    .diff      (diff),
    .part      (part),
    .weight    (weight),
    .exact_q   (exact_q),
    .diff_nxt  (diff_nxt),
    .part_nxt  (part_nxt),
    .exact_now (exact_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      diff    <= '0;
      part    <= '0;
      exact_q <= 1'b0;
    end else if (init) begin
      diff    <= {1'b0, radicand};
      part    <= '0;
      exact_q <= 1'b0;
    end else if (active) begin
      diff    <= diff_nxt;
      part    <= part_nxt;
      exact_q <= exact_now;
    end
  end

  assign raw_root = part[N-1:0];

  nr_isqrt_fix #(.N(N)) u_fix (
    .clk        (clk),
    .rst        (rst),
    .init       (init),
    .raw_done   (raw_done),
    .raw_root   (raw_root),
    .diff_neg   (diff[DW-1]),
    .root       (root),
    .root_valid (root_valid)
  );

  // R5: after an exact hit the partial root only shifts down
  a_r5_exact_shift: assert property (@(posedge clk) disable iff (rst)
    (active && !init && exact_now) |=> part == ($past(part) >> 1));

  // R5: after an exact hit the difference is frozen
  a_r5_exact_freeze: assert property (@(posedge clk) disable iff (rst)
    (active && !init && exact_now) |=> diff == $past(diff));

  // R4: a result reached without an exact hit is odd
  a_r4_raw_odd: assert property (@(posedge clk) disable iff (rst)
    ($rose(raw_done) && !exact_q) |-> part[0]);

  // R2: init clears the partial root
  a_r2_init_clear: assert property (@(posedge clk) disable iff (rst)
    init |=> part == '0);

endmodule

// File: tb/test_nr_isqrt.sv
module test_nr_isqrt;

  localparam int N      = 6;
  localparam int RW     = 2 * N;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init = 1'b0;
  logic [RW-1:0] radicand = '0;
  logic [N-1:0]  raw_root;
  logic          raw_done;
  logic [N-1:0]  root;
  logic          root_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  nr_isqrt #(.N(N)) i_nr_isqrt (
    .clk        (clk),
    .rst        (rst),
    .init       (init),
    .radicand   (radicand),
    .raw_root   (raw_root),
    .raw_done   (raw_done),
    .root       (root),
    .root_valid (root_valid)
  );

  function automatic int floor_sqrt(input int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Pulse init with x for one edge, leaving the unit running
  task automatic start_op(input int x);
    @(negedge clk);
    init     = 1'b1;
    radicand = RW'(x);
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic run_op(input int x, input string tag, input bit hold);
    int cyc;
    int fl;
    int raw;
    @(negedge clk);
    init     = 1'b1;
    radicand = RW'(x);
    @(negedge clk);
    chk(raw_root == 0, {tag, " R2 raw_root cleared"}, int'(raw_root), 0);
    chk(!raw_done && !root_valid, {tag, " R2 flags cleared"},
        int'({raw_done, root_valid}), 0);
    init = 1'b0;
    cyc = 0;
    while (!raw_done && cyc < N + 4) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == N, {tag, " R3 latency"}, cyc, N);
    fl  = floor_sqrt(x);
    raw = int'(raw_root);
    if (fl * fl == x)
      chk(raw == fl, {tag, " R5 exact raw root"}, raw, fl);
    else
      chk((raw % 2 == 1) && (raw == fl || raw == fl + 1),
          {tag, " R4 raw odd within one"}, raw, fl);
    chk(!root_valid, {tag, " R6 valid not early"}, int'(root_valid), 0);
    @(negedge clk);
    chk(root_valid, {tag, " R6 valid rises"}, int'(root_valid), 1);
    chk(int'(root) == fl, {tag, " R6 corrected root"}, int'(root), fl);
    if (hold) begin
      repeat (3) @(negedge clk);
      chk(root_valid && raw_done && int'(root) == fl && int'(raw_root) == raw,
          {tag, " R7 hold"}, int'(root), fl);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!raw_done && !root_valid, "R1 flags after reset",
        int'({raw_done, root_valid}), 0);
    chk(root == 0 && raw_root == 0, "R1 roots after reset",
        int'(root), 0);
    rst = 1'b0;

    // Boundary values first
    run_op(0, "edge", 1'b1);
    run_op(1, "edge", 1'b1);
    run_op(2, "edge", 1'b1);
    run_op((1 << RW) - 1, "edge", 1'b1);
    run_op(((1 << N) - 1) * ((1 << N) - 1), "edge", 1'b1);

    // Exhaustive sweep of every radicand
    for (int x = 0; x < (1 << RW); x++) begin
      run_op(x, "sweep", (x % 97) == 0);
    end

    // R8: restart in the middle of an operation
    start_op((1 << RW) - 1);
    repeat (2) @(negedge clk);
    run_op(17, "R8", 1'b1);
    start_op(0);
    repeat (N - 1) @(negedge clk);
    run_op(1000, "R8", 1'b1);
    start_op(1024);
    @(negedge clk);
    run_op(48, "R8", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule